// File: doc/BRIEF.md
# Two-Channel Edge-Driven Pulse Counter

This block is one counting unit. It has two channels, and each channel watches a pulse input and a control input. A rising or falling edge on a channel's pulse input moves a shared signed 16-bit count up or down. Each edge type has its own programmable action per channel. The level of the channel's control input can reverse that action, and a separate setting applies for each of the two levels.

All four inputs first pass through a two-flop synchronizer. An optional glitch filter follows. With the filter on, a new level is accepted only after it has held for a programmed number of clock cycles. The two channel steps produced in one cycle are added together. The count can be cleared at any time and frozen with a pause input. All configuration arrives on plain input ports that a register block elsewhere holds static.

Top module: `pulse_count_unit`

## Requirements
- R1: While reset is asserted and after it is released, `count_o` reads 0 until the first counted edge.
- R2: For channel c, the field `rise_mode_i[2c+1:2c]` sets the action on a rising filtered pulse edge and `fall_mode_i[2c+1:2c]` sets the action on a falling one. Code 1 adds one and code 2 subtracts one, before the control modifier is applied.
- R3: Channel c uses `ctl_hi_mode_i[2c+1:2c]` while its filtered control level is 1 and `ctl_lo_mode_i[2c+1:2c]` while it is 0. Code 0 keeps the edge's direction and code 1 reverses it.
- R4: The edge-mode codes 0 and 3 produce no step and never alter the count. The control-mode codes 2 and 3 behave like code 0 and keep the direction.
- R5: The steps of both channels in one cycle are summed. Opposite steps cancel, equal steps add, and the count moves by at most 2 per cycle.
- R6: While `pause_i` is 1 and `clear_i` is 0, the count holds its value. Edges that arrive during a pause are dropped, and counting resumes once pause falls.
- R7: `clear_i` sets the count to 0 at the next clock edge. It takes priority over both pause and counting.
- R8: With `filt_en_i` = 1 and threshold T = `filt_thr_i`, a synchronized level change on a pulse or control input is accepted only after T consecutive samples. A pulse shorter than T cycles is ignored. A pulse of T cycles or more is accepted.
- R9: With `filt_en_i` = 0, the synchronized level passes straight through, so a pulse one cycle wide is counted.
- R10: With the filter disabled, an input change that is set up before clock edge k shows up in `count_o` after edge k+3 and not earlier.
- R11: `count_o` is two's complement. Decrementing from 0 gives 16'hFFFF, which is -1, and the count wraps at 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sig_i | input | 2 | Pulse input, one bit per channel |
| ctl_i | input | 2 | Control input, one bit per channel |
| filt_en_i | input | 1 | Glitch filter enable |
| filt_thr_i | input | 10 | Filter threshold in clock cycles |
| rise_mode_i | input | 4 | Rising-edge action, 2 bits per channel |
| fall_mode_i | input | 4 | Falling-edge action, 2 bits per channel |
| ctl_hi_mode_i | input | 4 | Direction modifier while control is high, 2 bits per channel |
| ctl_lo_mode_i | input | 4 | Direction modifier while control is low, 2 bits per channel |
| clear_i | input | 1 | Synchronous count clear |
| pause_i | input | 1 | Count freeze |
| count_o | output | 16 | Signed count value |

## Verification
The assertions assume that the mode and filter fields stay stable around counted edges. They also assume that `clear_i` and `pause_i` are driven synchronously, since the properties relate the count only to these inputs in the previous cycle. The stimulus changes configuration only while the pulse inputs are idle and after all earlier edges have settled. It drives every input at the falling clock edge. It keeps each pulse level for at least the filter threshold when that pulse is meant to be counted, and deliberately shorter when it is meant to be rejected.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef logic signed [1:0] step_t;

  localparam logic [1:0] EDGE_INC = 2'd1;
  localparam logic [1:0] EDGE_DEC = 2'd2;
  localparam logic [1:0] LVL_FLIP = 2'd1;

  // codes 0 and 3 give no step
  function automatic step_t edge_step(input logic [1:0] mode);
    case (mode)
      EDGE_INC: edge_step = 2'sd1;
      EDGE_DEC: edge_step = -2'sd1;
      default:  edge_step = 2'sd0;
    endcase
  endfunction
endpackage

// File: rtl/pcu_filter.sv
module pcu_filter #(
  parameter int THR_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             raw_i,
  input  logic             en_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             lvl_o
);
  logic             s1_q, s2_q, lvl_q;
  logic [THR_W-1:0] run_q;
  logic             accept;

  // current sample is run_q+1 consecutive differing samples
  assign accept = ({1'b0, run_q} + (THR_W+1)'(1)) >= {1'b0, thr_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      lvl_q <= 1'b0;
      run_q <= '0;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
      if (!en_i) begin
        lvl_q <= s2_q;
        run_q <= '0;
      end else if (s2_q == lvl_q) begin
        run_q <= '0;
      end else if (accept) begin
        lvl_q <= s2_q;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/pcu_chan.sv
module pcu_chan
  import pcu_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sig_lvl_i,
  input  logic       ctl_lvl_i,
  input  logic [1:0] rise_mode_i,
  input  logic [1:0] fall_mode_i,
  input  logic [1:0] hi_mode_i,
  input  logic [1:0] lo_mode_i,
  output step_t      step_o
);
  logic  prev_q;
  logic  rise, fall, flip;
  step_t base;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sig_lvl_i;
  end

  assign rise = sig_lvl_i & ~prev_q;
  assign fall = ~sig_lvl_i & prev_q;
  assign flip = ctl_lvl_i ? (hi_mode_i == LVL_FLIP) : (lo_mode_i == LVL_FLIP);

  always_comb begin
    if (rise)      base = edge_step(rise_mode_i);
    else if (fall) base = edge_step(fall_mode_i);
    else           base = 2'sd0;
    step_o = flip ? -base : base;
  end
endmodule

// File: rtl/pulse_count_unit.sv
module pulse_count_unit
  import pcu_pkg::*;
#(
  parameter int N_CH  = 2,
  parameter int CNT_W = 16,
  parameter int THR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CH-1:0]   sig_i,
  input  logic [N_CH-1:0]   ctl_i,
  input  logic              filt_en_i,
  input  logic [THR_W-1:0]  filt_thr_i,
  input  logic [2*N_CH-1:0] rise_mode_i,
  input  logic [2*N_CH-1:0] fall_mode_i,
  input  logic [2*N_CH-1:0] ctl_hi_mode_i,
  input  logic [2*N_CH-1:0] ctl_lo_mode_i,
  input  logic              clear_i,
  input  logic              pause_i,
  output logic [CNT_W-1:0]  count_o
);
  localparam int SUM_W = $clog2(N_CH + 1) + 1;

  logic [N_CH-1:0]          sig_lvl, ctl_lvl;
  step_t                    step [N_CH];
  logic signed [SUM_W-1:0]  sum;
  logic [CNT_W-1:0]         count_q;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    pcu_filter #(.THR_W(THR_W)) u_sig_filt (
      .clk_i, .rst_ni, .raw_i(sig_i[c]), .en_i(filt_en_i),
      .thr_i(filt_thr_i), .lvl_o(sig_lvl[c])
    );
    pcu_filter #(.THR_W(THR_W)) u_ctl_filt (
      .clk_i, .rst_ni, .raw_i(ctl_i[c]), .en_i(filt_en_i),
      .thr_i(filt_thr_i), .lvl_o(ctl_lvl[c])
    );
    pcu_chan u_chan (
      .clk_i, .rst_ni,
      .sig_lvl_i  (sig_lvl[c]),
      .ctl_lvl_i  (ctl_lvl[c]),
      .rise_mode_i(rise_mode_i[2*c+:2]),
      .fall_mode_i(fall_mode_i[2*c+:2]),
      .hi_mode_i  (ctl_hi_mode_i[2*c+:2]),
      .lo_mode_i  (ctl_lo_mode_i[2*c+:2]),
      .step_o     (step[c])
    );
  end

  always_comb begin
    sum = '0;
    for (int c = 0; c < N_CH; c++) begin
      sum = sum + {{(SUM_W-2){step[c][1]}}, step[c]};
    end
  end

  // clear > pause > count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      count_q <= '0;
    else if (clear_i) count_q <= '0;
    else if (!pause_i)
      count_q <= count_q + {{(CNT_W-SUM_W){sum[SUM_W-1]}}, sum};
  end

  assign count_o = count_q;
endmodule

// File: rtl/pulse_count_unit_chk.sv
module pulse_count_unit_chk #(
  parameter int N_CH  = 2,
  parameter int CNT_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clear_i,
  input logic              pause_i,
  input logic [2*N_CH-1:0] rise_mode_i,
  input logic [2*N_CH-1:0] fall_mode_i,
  input logic [CNT_W-1:0]  count_o
);
  logic no_edge_action;

  always_comb begin
    no_edge_action = 1'b1;
    for (int c = 0; c < N_CH; c++) begin
      if (rise_mode_i[2*c+:2] inside {2'd1, 2'd2}) no_edge_action = 1'b0;
      if (fall_mode_i[2*c+:2] inside {2'd1, 2'd2}) no_edge_action = 1'b0;
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni) p_reset_zero_r1: assert (count_o == '0);
  end

  p_bad_mode_still_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (no_edge_action && !clear_i) |=> $stable(count_o));

  p_step_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> ($signed(count_o - $past(count_o)) <= 2 &&
                  $signed(count_o - $past(count_o)) >= -2));

  p_pause_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pause_i && !clear_i) |=> $stable(count_o));

  p_clear_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (count_o == '0));
endmodule

bind pulse_count_unit pulse_count_unit_chk #(.N_CH(N_CH), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/pulse_count_unit_tb_top.sv
`timescale 1ns/1ps
module pulse_count_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  sig_i = '0, ctl_i = '0;
  logic        filt_en_i = 1'b0;
  logic [9:0]  filt_thr_i = '0;
  logic [3:0]  rise_mode_i = '0, fall_mode_i = '0;
  logic [3:0]  ctl_hi_mode_i = '0, ctl_lo_mode_i = '0;
  logic        clear_i = 1'b0, pause_i = 1'b0;
  logic [15:0] count_o;

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];
  int    checks = 0, failures = 0;
  bit    done = 0;

  always #4 clk_i = ~clk_i;

  pulse_count_unit dut_i (.*);

  task automatic check_now(input logic [15:0] exp, input string tag);
    checks++;
    if (count_o !== exp) begin
      failures++;
      $display("FAIL %s: count=%0d expected=%0d", tag, $signed(count_o), $signed(exp));
    end
  endtask

  task automatic expect_cnt(input logic [15:0] exp, input string tag);
    item_t it;
    it.exp = exp;
    it.tag = tag;
    sb_q.push_back(it);
    repeat (2) @(negedge clk_i);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pulse(input logic [1:0] mask, input int hi_w, input int lo_w);
    sig_i = sig_i | mask;
    cyc(hi_w);
    sig_i = sig_i & ~mask;
    cyc(lo_w);
  endtask

  task automatic settle();
    cyc(int'(filt_thr_i) + 6);
  endtask

  // monitor: compares each expected item at the next falling edge
  initial begin
    forever begin
      item_t it;
      wait (sb_q.size() != 0);
      @(negedge clk_i);
      it = sb_q.pop_front();
      check_now(it.exp, it.tag);
    end
  end

  initial begin
    cyc(3);
    check_now(16'd0, "R1 in reset");
    rst_ni = 1'b1;
    cyc(2);
    expect_cnt(16'd0, "R1 after reset");

    rise_mode_i = 4'b0001;
    repeat (3) pulse(2'b01, 2, 2);
    settle();
    expect_cnt(16'd3, "R2 rise inc");

    rise_mode_i = 4'b0000; fall_mode_i = 4'b0010;
    repeat (2) pulse(2'b01, 2, 2);
    settle();
    expect_cnt(16'd1, "R2 fall dec");

    rise_mode_i = 4'b0001; fall_mode_i = 4'b0001;
    pulse(2'b01, 2, 2);
    settle();
    expect_cnt(16'd3, "R2 both edges inc");

    fall_mode_i = 4'b0000; ctl_hi_mode_i = 4'b0001; ctl_i = 2'b01;
    settle();
    repeat (2) pulse(2'b01, 2, 2);
    settle();
    expect_cnt(16'd1, "R3 high level reverses");

    ctl_hi_mode_i = 4'b0000; ctl_lo_mode_i = 4'b0001; ctl_i = 2'b00;
    settle();
    pulse(2'b01, 2, 2);
    settle();
    expect_cnt(16'd0, "R3 low level reverses");
    pulse(2'b01, 2, 2);
    settle();
    expect_cnt(16'hFFFF, "R11 below zero");
    pulse(2'b01, 2, 2);
    settle();
    expect_cnt(16'hFFFE, "R11 minus two");

    ctl_lo_mode_i = 4'b0010;
    pulse(2'b01, 2, 2);
    settle();
    expect_cnt(16'hFFFF, "R4 ctl code 2 keeps direction");
    ctl_lo_mode_i = 4'b0000;

    rise_mode_i = 4'b0011; fall_mode_i = 4'b0011;
    repeat (2) pulse(2'b01, 2, 2);
    settle();
    expect_cnt(16'hFFFF, "R4 edge code 3 ignored");
    rise_mode_i = 4'b0000; fall_mode_i = 4'b0000;
    pulse(2'b01, 2, 2);
    settle();
    expect_cnt(16'hFFFF, "R4 edge code 0 ignored");

    rise_mode_i = 4'b1001;
    repeat (2) pulse(2'b11, 2, 2);
    settle();
    expect_cnt(16'hFFFF, "R5 opposite steps cancel");
    rise_mode_i = 4'b0101;
    pulse(2'b11, 2, 2);
    settle();
    expect_cnt(16'd1, "R5 equal steps add");
    pulse(2'b10, 2, 2);
    settle();
    expect_cnt(16'd2, "R2 channel 1 field");

    pause_i = 1'b1;
    cyc(1);
    pulse(2'b01, 2, 2);
    settle();
    expect_cnt(16'd2, "R6 pause holds");
    pause_i = 1'b0;
    pulse(2'b01, 2, 2);
    settle();
    expect_cnt(16'd3, "R6 resume");

    pause_i = 1'b1; clear_i = 1'b1;
    cyc(1);
    clear_i = 1'b0; pause_i = 1'b0;
    cyc(1);
    expect_cnt(16'd0, "R7 clear beats pause");

    pulse(2'b01, 2, 2);
    settle();
    clear_i = 1'b1;
    pulse(2'b11, 2, 2);
    settle();
    clear_i = 1'b0;
    cyc(1);
    expect_cnt(16'd0, "R7 clear beats counting");

    // R10: edge set before edge k, visible only after k+3
    sig_i = 2'b01;
    cyc(3);
    check_now(16'd0, "R10 not before third edge");
    cyc(1);
    check_now(16'd1, "R10 at third edge");
    sig_i = 2'b00;
    settle();

    filt_en_i = 1'b1; filt_thr_i = 10'd5;
    settle();
    pulse(2'b01, 3, 8);
    settle();
    expect_cnt(16'd1, "R8 short pulse rejected");
    pulse(2'b01, 5, 8);
    settle();
    expect_cnt(16'd2, "R8 pulse at threshold accepted");
    ctl_hi_mode_i = 4'b0001;
    ctl_i = 2'b01;
    cyc(3);
    ctl_i = 2'b00;
    settle();
    pulse(2'b01, 6, 8);
    settle();
    expect_cnt(16'd3, "R8 control glitch rejected");
    ctl_hi_mode_i = 4'b0000;

    filt_en_i = 1'b0; filt_thr_i = 10'd0;
    settle();
    pulse(2'b01, 1, 3);
    settle();
    expect_cnt(16'd4, "R9 one cycle pulse counted");

    wait (sb_q.size() == 0);
    cyc(3);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule